// File: doc/BRIEF.md
# Flash Storage Host Controller Register Block

This block is the memory-mapped control and status register file of a serial flash storage host controller. Software reaches it over a 32-bit register bus, one full word per access. The block holds fixed capability and version words, and a write-one-to-clear interrupt status register with its enable register. It also holds the controller enable and status registers, the base addresses of the transfer and task lists, a link-layer command register and three command argument registers. A level interrupt output is high whenever an implemented status bit is both set and enabled.

No real link sits behind the block. A link-layer command written to the command register finishes on the same clock edge. Depending on the command code, it updates the controller status and power-mode fields, raises the completion interrupt, and leaves a success or failure code in the second argument register. Doorbell, clear and task run-stop registers accept writes and do nothing, so that a driver can run its start-up sequence against the block.

Top module: `fsh_regs`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, except two constant words. The capability word (offset 0x00) reads 0x0107021F with the default slot counts: bits [4:0] hold the transfer slot count minus one, bits [15:8] hold 2 (outstanding ready-to-transfer requests), bits [18:16] hold the task slot count minus one, bit 24 is set (64-bit addressing) and every other bit is 0. The version word (offset 0x08) reads 0x00000310.
- R2: A read strobe returns its data on `rdata` with `rvalid` high on the next cycle. Any address at or above 0xA0, or any offset that has no register, reads 0.
- R3: Interrupt status (0x20) is write-one-to-clear: each 1 in the write data clears that bit, and each 0 leaves it unchanged.
- R4: `irq` is high exactly when (status AND implemented mask 0x00071FFF AND enable) is nonzero, where enable is at 0x24. It follows every change to status or enable on the cycle after the write.
- R5: Writing bit 0 = 1 to controller enable (0x34) while that bit is 0 stores the bit and sets bit 3 (command-ready) of controller status (0x30).
- R6: Writing bit 0 = 0 to controller enable while that bit is 1 clears the bit and zeroes controller status. Writing the value already held changes nothing.
- R7: Command 0x16 (link startup), written at 0x90, sets controller status bits 0 (device present), 1 (transfer list ready) and 2 (task list ready). It also writes 0 (success) to argument 2 (0x98).
- R8: Command 0x17 (hibernate enter) sets status bit 6, writes 1 into controller status bits [10:8] and writes 0 to argument 2. Command 0x18 (hibernate exit) does the same but sets status bit 5 instead.
- R9: Any other command code writes 1 (failure) to argument 2 and leaves controller status unchanged. Every command write sets interrupt status bit 10 (command complete).
- R10: The low base-address registers of the transfer list (0x50) and the task list (0x70) store write data ANDed with 0xFFFFFC00. The high base-address registers (0x54, 0x74), transfer run-stop (0x60) and the arguments 1 to 3 (0x94, 0x98, 0x9C) store all 32 bits.
- R11: Writes to the transfer doorbell (0x58), the transfer clear (0x5C), the task doorbell (0x78), the task clear (0x7C) and the task run-stop (0x80), and writes at or above 0xA0, change no register. The completion notification register (0x64) is write-one-to-clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one 32-bit word |
| rd_en | input | 1 | Read strobe for one 32-bit word |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | High on the cycle that rdata carries the answer to a read |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the enable edge cases. It rewrites enable with the value already held after link startup has filled in the status bits. A design that reacted to the level rather than the change would clear those bits or set them again. Writing to status with a zero in the pending bit must leave that bit set, so a design that stored the data or cleared on zero fails the check.

The bench also sets the enable mask so that only some of the pending bits are enabled. A design that ignored the enable term, or ANDed the wrong operands, would drive `irq` the wrong way. An unknown command must still report completion and a failure code, and it must not touch the power-mode field. Reads of doorbell, clear and out-of-range offsets after all-ones writes show whether any of those writes was stored by mistake.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  localparam int unsigned DW = 32;

  // register offsets (bytes)
  localparam int unsigned OFF_CAP    = 'h00;
  localparam int unsigned OFF_VER    = 'h08;
  localparam int unsigned OFF_ISTAT  = 'h20;
  localparam int unsigned OFF_IEN    = 'h24;
  localparam int unsigned OFF_CSTAT  = 'h30;
  localparam int unsigned OFF_CEN    = 'h34;
  localparam int unsigned OFF_XL_LO  = 'h50;
  localparam int unsigned OFF_XL_HI  = 'h54;
  localparam int unsigned OFF_XL_DB  = 'h58;
  localparam int unsigned OFF_XL_CLR = 'h5C;
  localparam int unsigned OFF_XL_RUN = 'h60;
  localparam int unsigned OFF_XL_CN  = 'h64;
  localparam int unsigned OFF_TL_LO  = 'h70;
  localparam int unsigned OFF_TL_HI  = 'h74;
  localparam int unsigned OFF_TL_DB  = 'h78;
  localparam int unsigned OFF_TL_CLR = 'h7C;
  localparam int unsigned OFF_TL_RUN = 'h80;
  localparam int unsigned OFF_LCMD   = 'h90;
  localparam int unsigned OFF_ARG1   = 'h94;
  localparam int unsigned OFF_ARG2   = 'h98;
  localparam int unsigned OFF_ARG3   = 'h9C;

  // controller status field positions
  localparam int unsigned CS_DEV_PRESENT = 0;
  localparam int unsigned CS_XL_READY    = 1;
  localparam int unsigned CS_TL_READY    = 2;
  localparam int unsigned CS_CMD_READY   = 3;
  localparam int unsigned CS_PWR_LSB     = 8;
  localparam int unsigned CS_PWR_W       = 3;
  localparam logic [CS_PWR_W-1:0] PWR_LOCAL_OK = 3'd1;

  // interrupt status bit positions
  localparam int unsigned IS_HIB_EXIT  = 5;
  localparam int unsigned IS_HIB_ENTER = 6;
  localparam int unsigned IS_CMD_DONE  = 10;

  // link command codes and result codes
  localparam logic [DW-1:0] LC_LINK_START = 32'h16;
  localparam logic [DW-1:0] LC_HIB_ENTER  = 32'h17;
  localparam logic [DW-1:0] LC_HIB_EXIT   = 32'h18;
  localparam logic [DW-1:0] LC_RES_OK     = 32'h0;
  localparam logic [DW-1:0] LC_RES_FAIL   = 32'h1;

  localparam logic [DW-1:0] VERSION_WORD = 32'h0000_0310;
  localparam logic [DW-1:0] BASE_LO_MASK = 32'hFFFF_FC00;

  typedef struct packed {
    logic [DW-1:0] cen;
    logic [DW-1:0] cstat;
    logic [DW-1:0] istat;
    logic [DW-1:0] ien;
    logic [DW-1:0] xl_lo;
    logic [DW-1:0] xl_hi;
    logic [DW-1:0] xl_run;
    logic [DW-1:0] xl_cn;
    logic [DW-1:0] tl_lo;
    logic [DW-1:0] tl_hi;
    logic [DW-1:0] arg1;
    logic [DW-1:0] arg2;
    logic [DW-1:0] arg3;
  } regs_t;

  typedef struct packed {
    logic [DW-1:0] cstat_set;
    logic [DW-1:0] istat_set;
    logic          pwr_wr;
    logic [DW-1:0] result;
  } lcmd_eff_t;

  function automatic logic [DW-1:0] bit_at(input int unsigned pos);
    return DW'(1) << pos;
  endfunction

  function automatic logic [DW-1:0] cap_word(input int unsigned nxfer,
                                             input int unsigned ntask);
    logic [DW-1:0] c;
    c        = '0;
    c[4:0]   = 5'(nxfer - 1);
    c[15:8]  = 8'd2;
    c[18:16] = 3'(ntask - 1);
    c[24]    = 1'b1;
    return c;
  endfunction

  function automatic lcmd_eff_t lcmd_effect(input logic [DW-1:0] code);
    lcmd_eff_t e;
    e = '0;
    case (code)
      LC_LINK_START: begin
        e.cstat_set = bit_at(CS_DEV_PRESENT) | bit_at(CS_XL_READY) | bit_at(CS_TL_READY);
        e.result    = LC_RES_OK;
      end
      LC_HIB_ENTER: begin
        e.istat_set = bit_at(IS_HIB_ENTER);
        e.pwr_wr    = 1'b1;
        e.result    = LC_RES_OK;
      end
      LC_HIB_EXIT: begin
        e.istat_set = bit_at(IS_HIB_EXIT);
        e.pwr_wr    = 1'b1;
        e.result    = LC_RES_OK;
      end
      default: e.result = LC_RES_FAIL;
    endcase
    e.istat_set = e.istat_set | bit_at(IS_CMD_DONE);
    return e;
  endfunction

endpackage

// File: rtl/fsh_linkcmd.sv
module fsh_linkcmd
  import fsh_pkg::*;
(
  input  logic [DW-1:0] code,
  input  logic [DW-1:0] cstat_cur,
  input  logic [DW-1:0] istat_cur,
  output logic [DW-1:0] cstat_nxt,
  output logic [DW-1:0] istat_nxt,
  output logic [DW-1:0] result,
  output logic          cmd_known
);
  lcmd_eff_t eff;

  always_comb begin
    eff       = lcmd_effect(code);
    cstat_nxt = cstat_cur | eff.cstat_set;
    if (eff.pwr_wr)
      cstat_nxt[CS_PWR_LSB +: CS_PWR_W] = PWR_LOCAL_OK;
    istat_nxt = istat_cur | eff.istat_set;
    result    = eff.result;
    cmd_known = (eff.result == LC_RES_OK);
  end
endmodule

// File: rtl/fsh_irq.sv
module fsh_irq
  import fsh_pkg::*;
#(
  parameter logic [DW-1:0] IMPL_MASK = 32'h0007_1FFF
) (
  input  logic [DW-1:0] istat,
  input  logic [DW-1:0] ien,
  output logic          irq
);
  logic [DW-1:0] pending;
  assign pending = istat & IMPL_MASK & ien;
  assign irq     = |pending;
endmodule

// File: rtl/fsh_rdmux.sv
module fsh_rdmux
  import fsh_pkg::*;
#(
  parameter int unsigned AW          = 12,
  parameter int unsigned BLOCK_BYTES = 160,
  parameter int unsigned N_XFER      = 32,
  parameter int unsigned N_TASK      = 8
) (
  input  logic [AW-1:0] addr,
  input  regs_t         r,
  output logic          in_range,
  output logic [DW-1:0] data
);
  localparam logic [DW-1:0] CAP = cap_word(N_XFER, N_TASK);

  assign in_range = (addr < AW'(BLOCK_BYTES));

  always_comb begin
    data = '0;
    if (in_range) begin
      case (addr)
        AW'(OFF_CAP):    data = CAP;
        AW'(OFF_VER):    data = VERSION_WORD;
        AW'(OFF_ISTAT):  data = r.istat;
        AW'(OFF_IEN):    data = r.ien;
        AW'(OFF_CSTAT):  data = r.cstat;
        AW'(OFF_CEN):    data = r.cen;
        AW'(OFF_XL_LO):  data = r.xl_lo;
        AW'(OFF_XL_HI):  data = r.xl_hi;
        AW'(OFF_XL_RUN): data = r.xl_run;
        AW'(OFF_XL_CN):  data = r.xl_cn;
        AW'(OFF_TL_LO):  data = r.tl_lo;
        AW'(OFF_TL_HI):  data = r.tl_hi;
        AW'(OFF_ARG1):   data = r.arg1;
        AW'(OFF_ARG2):   data = r.arg2;
        AW'(OFF_ARG3):   data = r.arg3;
        default:         data = '0;
      endcase
    end
  end
endmodule

// File: rtl/fsh_regs.sv
module fsh_regs
  import fsh_pkg::*;
#(
  parameter int unsigned     AW          = 12,
  parameter int unsigned     BLOCK_BYTES = 160,
  parameter int unsigned     N_XFER      = 32,
  parameter int unsigned     N_TASK      = 8,
  parameter logic [DW-1:0]   IMPL_MASK   = 32'h0007_1FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          irq
);
  regs_t         r;
  logic          in_range;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] lc_cstat, lc_istat, lc_result;
  logic          lc_known;

  // named events for the assertions
  logic wr_ok, wr_istat, wr_cmd, wr_cen, cen_rise, cen_fall;
  assign wr_ok    = wr_en && in_range;
  assign wr_istat = wr_ok && (addr == AW'(OFF_ISTAT));
  assign wr_cmd   = wr_ok && (addr == AW'(OFF_LCMD));
  assign wr_cen   = wr_ok && (addr == AW'(OFF_CEN));
  assign cen_rise = wr_cen && !r.cen[0] &&  wdata[0];
  assign cen_fall = wr_cen &&  r.cen[0] && !wdata[0];

  fsh_linkcmd u_lcmd (
    .code      (wdata),
    .cstat_cur (r.cstat),
    .istat_cur (r.istat),
    .cstat_nxt (lc_cstat),
    .istat_nxt (lc_istat),
    .result    (lc_result),
    .cmd_known (lc_known)
  );

  fsh_irq #(.IMPL_MASK(IMPL_MASK)) u_irq (
    .istat (r.istat),
    .ien   (r.ien),
    .irq   (irq)
  );

  fsh_rdmux #(
    .AW(AW), .BLOCK_BYTES(BLOCK_BYTES), .N_XFER(N_XFER), .N_TASK(N_TASK)
  ) u_rdmux (
    .addr     (addr),
    .r        (r),
    .in_range (in_range),
    .data     (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r <= '0;
    end else if (wr_ok) begin
      case (addr)
        AW'(OFF_ISTAT):  r.istat  <= r.istat & ~wdata;
        AW'(OFF_IEN):    r.ien    <= wdata;
        AW'(OFF_CEN): begin
          if (cen_rise) begin
            r.cen[0]             <= 1'b1;
            r.cstat[CS_CMD_READY] <= 1'b1;
          end else if (cen_fall) begin
            r.cen[0] <= 1'b0;
            r.cstat  <= '0;
          end
        end
        AW'(OFF_XL_LO):  r.xl_lo  <= wdata & BASE_LO_MASK;
        AW'(OFF_XL_HI):  r.xl_hi  <= wdata;
        AW'(OFF_XL_RUN): r.xl_run <= wdata;
        AW'(OFF_XL_CN):  r.xl_cn  <= r.xl_cn & ~wdata;
        AW'(OFF_TL_LO):  r.tl_lo  <= wdata & BASE_LO_MASK;
        AW'(OFF_TL_HI):  r.tl_hi  <= wdata;
        AW'(OFF_LCMD): begin
          r.cstat <= lc_cstat;
          r.istat <= lc_istat;
          r.arg2  <= lc_result;
        end
        AW'(OFF_ARG1):   r.arg1   <= wdata;
        AW'(OFF_ARG2):   r.arg2   <= wdata;
        AW'(OFF_ARG3):   r.arg3   <= wdata;
        default: ;  // doorbells, clears, task run-stop: accepted, no effect
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);  // R2
  AST_RD_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_range) |=> (rdata == '0));  // R2
  AST_ISTAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    wr_istat |=> ((r.istat & $past(wdata)) == '0));  // R3
  AST_IRQ_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_istat && (wdata == '1)) |=> !irq);  // R4
  AST_CEN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cen_rise |=> (r.cen[0] && r.cstat[CS_CMD_READY]));  // R5
  AST_CEN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cen_fall |=> (!r.cen[0] && (r.cstat == '0)));  // R6
  AST_LINK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && (wdata == LC_LINK_START)) |=> ((r.cstat[2:0] == 3'b111) && (r.arg2 == LC_RES_OK)));  // R7
  AST_HIB_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && ((wdata == LC_HIB_ENTER) || (wdata == LC_HIB_EXIT)))
      |=> (r.cstat[CS_PWR_LSB +: CS_PWR_W] == PWR_LOCAL_OK));  // R8
  AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> r.istat[IS_CMD_DONE]);  // R9
  AST_CMD_FAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !lc_known) |=> ((r.arg2 == LC_RES_FAIL) && $stable(r.cstat)));  // R9
  AST_XL_BASE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && (addr == AW'(OFF_XL_LO))) |=> (r.xl_lo[9:0] == '0));  // R10
  AST_OOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> $stable(r));  // R11
endmodule

// File: tb/fsh_regs_bench.sv
module fsh_regs_bench;
  localparam int unsigned AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  fsh_regs u_fsh_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  // expected capability word restated from field positions
  function automatic logic [31:0] exp_cap(input int nx, input int nt);
    return ((nt - 1) << 16) + (2 << 8) + (nx - 1) + (1 << 24);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops the scoreboard when a read result appears
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (q_exp.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected rvalid actual=%08h expected=none", rdata);
      end else begin
        check(q_tag.pop_front(), rdata, q_exp.pop_front());
      end
    end
  end

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing read results actual=%0d expected=0", q_exp.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rvalid after reset", {31'b0, rvalid}, 32'h0);
    check("R4 irq after reset", {31'b0, irq}, 32'h0);
    rd('h00, exp_cap(32, 8), "R1 capability");
    rd('h08, 32'h0000_0310, "R1 version");
    rd('h20, 32'h0, "R1 status reset");
    rd('h30, 32'h0, "R1 controller status reset");
    // R2 unmapped and out of range
    rd('h04, 32'h0, "R2 unmapped offset");
    rd('hA0, 32'h0, "R2 first offset past block");
    rd('hFFC, 32'h0, "R2 far offset");
    // R5 enable rise
    wr('h34, 32'h1);
    rd('h34, 32'h1, "R5 enable stored");
    rd('h30, 32'h8, "R5 command ready");
    // R7 link startup
    wr('h98, 32'hAAAA_5555);
    wr('h90, 32'h16);
    rd('h30, 32'hF, "R7 status bits");
    rd('h98, 32'h0, "R7 success code");
    rd('h20, 32'h400, "R9 completion after startup");
    check("R4 irq masked by enable", {31'b0, irq}, 32'h0);
    // R6 same value rewrite is a no-op
    wr('h34, 32'h1);
    rd('h30, 32'hF, "R6 rewrite of 1 keeps status");
    // R4 / R3
    wr('h24, 32'h400);
    check("R4 irq enabled", {31'b0, irq}, 32'h1);
    wr('h20, 32'h1);
    rd('h20, 32'h400, "R3 zero bit leaves status");
    check("R3 irq still high", {31'b0, irq}, 32'h1);
    wr('h20, 32'h400);
    rd('h20, 32'h0, "R3 one bit clears status");
    check("R4 irq low after clear", {31'b0, irq}, 32'h0);
    // R8 hibernate enter
    wr('h98, 32'h1234);
    wr('h90, 32'h17);
    rd('h20, 32'h440, "R8 enter status bits");
    rd('h30, 32'h10F, "R8 power field after enter");
    rd('h98, 32'h0, "R8 enter success");
    check("R4 irq from completion", {31'b0, irq}, 32'h1);
    wr('h24, 32'h40);
    check("R4 irq from enter bit", {31'b0, irq}, 32'h1);
    wr('h20, 32'h40);
    check("R4 irq off, only unenabled bit", {31'b0, irq}, 32'h0);
    // R8 hibernate exit
    wr('h20, 32'hFFFF_FFFF);
    wr('h90, 32'h18);
    rd('h20, 32'h420, "R8 exit status bits");
    // R9 unknown command
    wr('h20, 32'hFFFF_FFFF);
    wr('h90, 32'h99);
    rd('h98, 32'h1, "R9 failure code");
    rd('h20, 32'h400, "R9 completion on unknown");
    rd('h30, 32'h10F, "R9 status untouched");
    // R10 base addresses and full-width registers
    wr('h50, 32'hFFFF_FFFF);
    wr('h54, 32'h1234_5678);
    wr('h70, 32'h0000_07FF);
    wr('h74, 32'hCAFE_F00D);
    wr('h60, 32'h0000_0001);
    wr('h94, 32'hDEAD_BEEF);
    wr('h9C, 32'h0BAD_F00D);
    rd('h50, 32'hFFFF_FC00, "R10 transfer base low masked");
    rd('h54, 32'h1234_5678, "R10 transfer base high");
    rd('h70, 32'h0000_0400, "R10 task base low masked");
    rd('h74, 32'hCAFE_F00D, "R10 task base high");
    rd('h60, 32'h1, "R10 run-stop stored");
    rd('h94, 32'hDEAD_BEEF, "R10 argument 1");
    rd('h9C, 32'h0BAD_F00D, "R10 argument 3");
    // R11 ignored writes
    foreach (q_exp[i]) begin end
    for (int k = 0; k < 5; k++) begin
      int offs[5] = '{'h58, 'h5C, 'h78, 'h7C, 'h80};
      wr(offs[k], 32'hFFFF_FFFF);
      rd(offs[k], 32'h0, "R11 no-effect register");
    end
    wr('hA0, 32'hFFFF_FFFF);
    wr('hA4, 32'hFFFF_FFFF);
    rd('hA0, 32'h0, "R11 out-of-range write");
    rd('h94, 32'hDEAD_BEEF, "R11 argument 1 untouched");
    wr('h64, 32'hFFFF_FFFF);
    rd('h64, 32'h0, "R11 completion notification");
    // R6 enable fall
    wr('h34, 32'h0);
    rd('h34, 32'h0, "R6 enable cleared");
    rd('h30, 32'h0, "R6 status zeroed");
    // R1 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd('h94, 32'h0, "R1 argument after reset");
    rd('h24, 32'h0, "R1 enable mask after reset");
    rd('h00, exp_cap(32, 8), "R1 capability after reset");
    finish_run();
  end
endmodule